// File: doc/BRIEF.md
# Sampling Converter Conversion Sequencer

This block is the digital controller of a successive-approximation sampling converter. It merges an active-low chip-select and an active-low read/convert control into one request. When both are low, the falling edge of whichever control went low second starts a conversion. On that clock edge the incoming sample word is frozen in a hold register, and `busy` drops. A down-counter then times a fixed conversion interval. At the end of the interval the frozen word, in the selected coding, moves into the result register. `busy` rises, and a one-cycle `resultLatched` pulse tells a downstream serial shifter that a new word is ready.

After every conversion an acquisition window of fixed length follows, so that one conversion plus one acquisition fills a whole sample period. New start edges are not accepted while a conversion runs or during that window. Power-down blocks all new requests and keeps the stored result. The analog part is not modelled: `sampleIn` carries the word that the capacitor array would have produced.

Top module: `sar_conv_seq`

## Requirements
- R1: A conversion starts on the clock edge at which the OR of `csN` and `rcN` is first seen low after being high, whichever control fell last. On that edge the hold register captures `sampleIn`.
- R2: `busy` is 1 out of reset and while idle. It goes low in the cycle after the start edge and stays low for exactly `CONV_CYCLES` clock cycles.
- R3: `resultLatched` is high for exactly the one cycle in which `busy` returns high. `resultOut` takes its new value in that same cycle and changes at no other time.
- R4: A start edge that arrives while `busy` is low is ignored. The running conversion keeps its length and its captured sample.
- R5: A start edge that arrives during the `CYCLE_CYCLES - CONV_CYCLES` cycles after `busy` rises is dropped and not deferred. `busy` stays high.
- R6: While `pwrDown` is 1, start edges are ignored. `busy` stays high, and `resultOut` and `resultValid` keep their values.
- R7: With `fmtStraight` = 1 the stored word equals the held sample. With `fmtStraight` = 0 the stored word is the held sample with its most significant bit inverted, which is two's complement. The format is sampled on the edge that stores the result.
- R8: The first conversion after reset, and the first conversion after `pwrDown` has been high, store a word with `resultValid` = 0. Every later conversion sets `resultValid` = 1.
- R9: Out of reset: `busy` = 1, `resultLatched` = 0, `resultValid` = 0, `resultOut` = 0.
- R10: Changes on `sampleIn` after the start edge have no effect on the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| rcN | input | 1 | Active-low read/convert control |
| pwrDown | input | 1 | 1 blocks new conversions |
| fmtStraight | input | 1 | 1 = straight binary, 0 = two's complement |
| sampleIn | input | DATA_W | Converted value supplied by the stand-in source |
| busy | output | 1 | Low while a conversion is in progress |
| resultOut | output | DATA_W | Stored conversion word |
| resultValid | output | 1 | Stored word is a valid conversion |
| resultLatched | output | 1 | One-cycle pulse when a new word is stored |

## Verification
The bench builds the block with `DATA_W` = 16, `CONV_CYCLES` = 5 and `CYCLE_CYCLES` = 9, which gives a 4-cycle acquisition window. With counts this short, every cycle of each conversion and acquisition interval can be checked one by one. Dozens of back-to-back conversions then fit easily, sweeping both codings, both control orders and the code corners 0000, 7FFF, 8000 and FFFF. The short windows also make it cheap to place stray start edges inside a conversion, inside the acquisition window and during power-down, and to follow the valid flag through reset and power-down recovery.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    PH_READY = 2'd0,
    PH_CONV  = 2'd1,
    PH_ACQ   = 2'd2
  } seq_phase_t;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic capture;   // freeze sampleIn into the hold register
    logic commit;    // move formatted hold word into the result register
    logic coldMark;  // analog side is powered down, next result is invalid
  } seq_strobe_t;

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int CONV_CYCLES  = 220,
  parameter int CYCLE_CYCLES = 400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csN,
  input  logic        rcN,
  input  logic        pwrDown,
  output seq_strobe_t strobe,
  output logic        busy,
  output logic        resultLatched
);

  localparam int ACQ_CYCLES = CYCLE_CYCLES - CONV_CYCLES;
  localparam int MAX_COUNT  = (CONV_CYCLES > ACQ_CYCLES) ? CONV_CYCLES : ACQ_CYCLES;
  localparam int CNT_W      = $clog2(MAX_COUNT + 1);
  localparam logic [CNT_W-1:0] CONV_LOAD = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] ACQ_LOAD  = CNT_W'(ACQ_CYCLES - 1);

  seq_phase_t       phase;
  logic [CNT_W-1:0] cnt;
  logic             prevCombined;
  logic             combined;
  logic             startEdge;
  logic             startOk;
  logic             convDone;
  logic             busyQ;
  logic             latchQ;

  // both controls are active low and ORed: request is active only when both low
  assign combined  = csN | rcN;
  assign startEdge = prevCombined & ~combined;
  assign startOk   = startEdge && (phase == PH_READY) && !pwrDown;
  assign convDone  = (phase == PH_CONV) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= PH_READY;
      cnt          <= '0;
      prevCombined <= 1'b1;
      busyQ        <= 1'b1;
      latchQ       <= 1'b0;
    end else begin
      prevCombined <= combined;
      latchQ       <= 1'b0;
      unique case (phase)
        PH_READY: begin
          if (startOk) begin
            phase <= PH_CONV;
            cnt   <= CONV_LOAD;
            busyQ <= 1'b0;
          end
        end
        PH_CONV: begin
          if (cnt == '0) begin
            phase  <= PH_ACQ;
            cnt    <= ACQ_LOAD;
            busyQ  <= 1'b1;
            latchQ <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_ACQ: begin
          if (cnt == '0) phase <= PH_READY;
          else           cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_READY;
      endcase
    end
  end

  always_comb begin
    strobe.capture  = startOk;
    strobe.commit   = convDone;
    strobe.coldMark = pwrDown;
  end

  assign busy          = busyQ;
  assign resultLatched = latchQ;

endmodule

// File: rtl/sar_seq_dpath.sv
module sar_seq_dpath
  import sar_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_strobe_t       strobe,
  input  logic              fmtStraight,
  input  logic [DATA_W-1:0] sampleIn,
  output logic [DATA_W-1:0] resultOut,
  output logic              resultValid
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] holdWord;
  logic [DATA_W-1:0] codedWord;
  logic              warm;
  logic [DATA_W-1:0] resultQ;
  logic              validQ;

  // two's complement differs from offset binary only in the top bit
  always_comb begin
    codedWord      = holdWord;
    codedWord[MSB] = holdWord[MSB] ^ ~fmtStraight;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdWord <= '0;
      resultQ  <= '0;
      validQ   <= 1'b0;
      warm     <= 1'b0;
    end else begin
      if (strobe.capture) holdWord <= sampleIn;
      if (strobe.commit) begin
        resultQ <= codedWord;
        validQ  <= warm;
      end
      if (strobe.coldMark)    warm <= 1'b0;
      else if (strobe.commit) warm <= 1'b1;
    end
  end

  assign resultOut   = resultQ;
  assign resultValid = validQ;

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int CONV_CYCLES  = 220,
  parameter int CYCLE_CYCLES = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csN,
  input  logic              rcN,
  input  logic              pwrDown,
  input  logic              fmtStraight,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              busy,
  output logic [DATA_W-1:0] resultOut,
  output logic              resultValid,
  output logic              resultLatched
);

  seq_strobe_t strobe;

  sar_seq_ctrl #(
    .CONV_CYCLES (CONV_CYCLES),
    .CYCLE_CYCLES(CYCLE_CYCLES)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .csN          (csN),
    .rcN          (rcN),
    .pwrDown      (pwrDown),
    .strobe       (strobe),
    .busy         (busy),
    .resultLatched(resultLatched)
  );

  sar_seq_dpath #(
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .fmtStraight(fmtStraight),
    .sampleIn   (sampleIn),
    .resultOut  (resultOut),
    .resultValid(resultValid)
  );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 220
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csN,
  input logic              rcN,
  input logic              pwrDown,
  input logic              busy,
  input logic [DATA_W-1:0] resultOut,
  input logic              resultLatched
);

  localparam int LW = $clog2(CONV_CYCLES + 2);
  localparam logic [LW-1:0] LMAX = LW'(CONV_CYCLES + 1);
  localparam logic [LW-1:0] LEXP = LW'(CONV_CYCLES);

  logic [LW-1:0] lowCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lowCnt <= '0;
    else if (busy)        lowCnt <= '0;
    else if (lowCnt != LMAX) lowCnt <= lowCnt + 1'b1;
  end

  // R1
  busy_fall_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(!(csN | rcN)) && !$past(pwrDown)));

  // R2
  conv_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (lowCnt == LEXP));

  // R3
  latch_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resultLatched |-> $rose(busy));

  // R3
  rise_has_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> resultLatched);

  // R3
  result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resultLatched |-> $stable(resultOut));

  // R6
  powerdown_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pwrDown) |=> busy);

endmodule

bind sar_conv_seq sar_seq_chk #(
  .DATA_W     (DATA_W),
  .CONV_CYCLES(CONV_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .csN          (csN),
  .rcN          (rcN),
  .pwrDown      (pwrDown),
  .busy         (busy),
  .resultOut    (resultOut),
  .resultLatched(resultLatched)
);

// File: tb/sim_sar_conv_seq.sv
module sim_sar_conv_seq;

  localparam int DATA_W = 16;
  localparam int CONV   = 5;
  localparam int CYCLE  = 9;
  localparam int ACQ    = CYCLE - CONV;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              csN = 1'b1;
  logic              rcN = 1'b1;
  logic              pwrDown = 1'b0;
  logic              fmtStraight = 1'b1;
  logic [DATA_W-1:0] sampleIn = '0;
  logic              busy;
  logic [DATA_W-1:0] resultOut;
  logic              resultValid;
  logic              resultLatched;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [DATA_W-1:0] lastRes = '0;
  logic              lastValid = 1'b0;

  always #5 clk = ~clk;

  sar_conv_seq #(
    .DATA_W(DATA_W), .CONV_CYCLES(CONV), .CYCLE_CYCLES(CYCLE)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .csN(csN), .rcN(rcN), .pwrDown(pwrDown),
    .fmtStraight(fmtStraight), .sampleIn(sampleIn), .busy(busy),
    .resultOut(resultOut), .resultValid(resultValid), .resultLatched(resultLatched)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one full conversion; leaves controls low, returns in the cycle after busy rises
  task automatic doConv(input logic [DATA_W-1:0] v, input logic fmt, input bit csLast,
                        input bit glitch, input logic expValid);
    logic [DATA_W-1:0] expRes;
    expRes = fmt ? v : (v ^ 16'h8000);
    @(negedge clk);
    sampleIn = v;
    fmtStraight = fmt;
    if (csLast) rcN = 1'b0; else csN = 1'b0;
    @(negedge clk);
    check("R1 no start before second control", 32'(busy), 32'd1);
    if (csLast) csN = 1'b0; else rcN = 1'b0;
    @(negedge clk);
    check("R1 busy low after start", 32'(busy), 32'd0);
    sampleIn = ~v;  // R10 later change must not matter
    for (int j = 1; j < CONV; j++) begin
      if (glitch && j == 1) rcN = 1'b1;
      if (glitch && j == 2) rcN = 1'b0;  // R4 new edge during conversion
      @(negedge clk);
      check(glitch ? "R4 busy held low" : "R2 busy held low", 32'(busy), 32'd0);
      check("R3 no early latch", 32'(resultLatched), 32'd0);
    end
    @(negedge clk);
    check("R2 busy rises after CONV cycles", 32'(busy), 32'd1);
    check("R3 latch pulse", 32'(resultLatched), 32'd1);
    check("R7 R10 stored word", 32'(resultOut), 32'(expRes));
    check("R8 valid flag", 32'(resultValid), 32'(expValid));
    lastRes = expRes;
    lastValid = expValid;
  endtask

  task automatic restore();
    csN = 1'b1;
    rcN = 1'b1;
    @(negedge clk);
    check("R3 pulse one cycle", 32'(resultLatched), 32'd0);
    repeat (ACQ + 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 busy", 32'(busy), 32'd1);
    check("R9 latched", 32'(resultLatched), 32'd0);
    check("R9 valid", 32'(resultValid), 32'd0);
    check("R9 result", 32'(resultOut), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // sweep of values, codings, control orders
    for (int i = 0; i < 48; i++) begin
      logic [DATA_W-1:0] v;
      case (i)
        0: v = 16'h0000;
        1: v = 16'hFFFF;
        2: v = 16'h7FFF;
        3: v = 16'h8000;
        default: v = DATA_W'(i * 16'h1571 + 16'h0203);
      endcase
      doConv(v, i[0], i[1], (i % 5) == 4, (i != 0));
      restore();
    end

    // R5 edge during acquisition is dropped
    doConv(16'h3C5A, 1'b1, 1'b0, 1'b0, 1'b1);
    rcN = 1'b1;
    @(negedge clk);
    rcN = 1'b0;
    for (int j = 0; j < ACQ + CONV; j++) begin
      @(negedge clk);
      check("R5 busy stays high", 32'(busy), 32'd1);
      check("R5 no latch", 32'(resultLatched), 32'd0);
    end
    csN = 1'b1;
    rcN = 1'b1;
    repeat (2) @(negedge clk);

    // R6 power-down
    pwrDown = 1'b1;
    sampleIn = 16'h1111;
    @(negedge clk);
    rcN = 1'b0;
    @(negedge clk);
    csN = 1'b0;
    for (int j = 0; j < CONV + 2; j++) begin
      @(negedge clk);
      check("R6 busy high", 32'(busy), 32'd1);
      check("R6 result kept", 32'(resultOut), 32'(lastRes));
      check("R6 valid kept", 32'(resultValid), 32'(lastValid));
    end
    csN = 1'b1;
    rcN = 1'b1;
    @(negedge clk);
    pwrDown = 1'b0;
    repeat (2) @(negedge clk);

    // R8 first conversion after power-down is invalid, then valid
    doConv(16'hA5A5, 1'b0, 1'b1, 1'b0, 1'b0);
    restore();
    doConv(16'h5A5A, 1'b1, 1'b0, 1'b0, 1'b1);
    restore();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule